// File: doc/BRIEF.md
# Flow-Through Burst SRAM Access Path

This block is the control and address path of a single-ported synchronous static RAM that serves four-word bursts. The RAM is one word of four byte lanes wide and `2^ADDR_W` words deep. All inputs are sampled on the rising clock edge. A host starts a burst with either of two active-low address strobes. One strobe belongs to the processor side and the other to the cache controller side.

A 2-bit counter then generates the two low address bits for the rest of the burst. It steps once for each clock that the advance input is held low. The order is either a linear wrap modulo four or an XOR-interleaved order, chosen by a static mode input.

Read data is flow-through. The word at the address registered on an edge shows on `dataOut` during the following clock, so a burst delivers words at a 2-1-1-1 rate. Writes go to the address that takes effect on the same edge, and byte-lane or global enables select which lanes are written. The output enable is combinational. Because the block has no bidirectional pad, `dataDrive` marks the cycles in which a pad would drive, and `dataOut` reads zero in every other cycle.

Top module: `burst_sram`

## Requirements
- R1: After reset the block is deselected with no read pending, so `dataDrive` is 0 and `dataOut` is 0.
- R2: A low `ctrlStrobeN` always loads `addrIn` and the select state from `chipSel`. When `chipSel` is 0 the block becomes deselected. While deselected, writes and advance cycles have no effect and `dataDrive` stays 0.
- R3: A low `procStrobeN` loads an address only when `chipSel` is 1. When `chipSel` is 0 it is ignored, and the current burst continues as if no strobe had been given.
- R4: With `interleave` = 0 the low two address bits run start+k modulo 4 for k = 0..3. For example, a start of 2 gives the order 2, 3, 0, 1. The upper address bits stay fixed for the whole burst.
- R5: With `interleave` = 1 the low two address bits run start XOR k for k = 0..3.
- R6: The burst counter steps only on edges where `advanceN` is 0 and no strobe loads. While `advanceN` is 1, the address and the read word are held.
- R7: A controller strobe in the middle of a burst abandons that burst and starts a new one at the new address.
- R8: With `globalWrN` = 1 and `byteWrEnN` = 0, lane i (bits 8i+7:8i) is written from `dataIn` when `laneEnN[i]` = 0. If every `laneEnN` bit is 1, nothing is written.
- R9: With `globalWrN` = 0, all four lanes are written, whatever the values of `laneEnN` and `byteWrEnN`.
- R10: An edge on which the processor strobe takes effect is always a read. Any write enables given on that edge are ignored.
- R11: After an edge that performs no write on a selected block, `dataOut` shows the word at the newly registered address during the next clock. After an edge that performs a write, `dataDrive` is 0.
- R12: While `outEnN` is 1, `dataDrive` is 0 and `dataOut` is 0. The output responds combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the control state |
| chipSel | input | 1 | Registered chip enable, sampled with a strobe |
| procStrobeN | input | 1 | Processor-side address strobe, active low |
| ctrlStrobeN | input | 1 | Controller-side address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| interleave | input | 1 | Burst order select: 1 for XOR order, 0 for linear order |
| addrIn | input | ADDR_W | Word address |
| byteWrEnN | input | 1 | Byte-write enable, active low |
| laneEnN | input | 4 | Per-lane write enables, active low |
| globalWrN | input | 1 | Write all lanes, active low |
| outEnN | input | 1 | Combinational output enable, active low |
| dataIn | input | 32 | Write data |
| dataOut | output | 32 | Read data, zero while not driving |
| dataDrive | output | 1 | High when the data pad would drive |

## Verification
The bench goes after the wrap from lane 3 back to lane 0 in both burst orders. A counter that carries into the upper address, or that applies the wrong order, returns the word from a neighbouring line. Held advance cycles are mixed into bursts, and a block that steps anyway skips a word. The bench also restarts a burst with the controller strobe partway through, and a block that keeps the old count returns the wrong start word. A deselected processor strobe must be dropped; a block that loads on it jumps to a new address. A write given on a processor-strobe edge must be dropped; a block that performs it corrupts the word. Partial lane masks, an all-disabled mask and a global write are each read back, which exposes a reversed lane mapping or wrong write priority.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int LANE_CNT = 4;

  typedef struct packed {
    logic                load;    // strobe takes effect: new start address
    logic                step;    // advance the burst counter
    logic [LANE_CNT-1:0] wrMask;  // lanes written on this edge
    logic                drive;   // read data on the pad
  } sramStrobes_t;
endpackage

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import burst_sram_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                chipSel,
  input  logic                procStrobeN,
  input  logic                ctrlStrobeN,
  input  logic                advanceN,
  input  logic                byteWrEnN,
  input  logic [LANE_CNT-1:0] laneEnN,
  input  logic                globalWrN,
  input  logic                outEnN,
  output sramStrobes_t        strobes
);
  logic                selected;
  logic                readActive;
  logic                procTakes;
  logic                selNext;
  logic [LANE_CNT-1:0] mask;

  always_comb begin
    procTakes     = !procStrobeN && chipSel;
    strobes.load  = procTakes || !ctrlStrobeN;
    selNext       = strobes.load ? chipSel : selected;
    strobes.step  = !strobes.load && selected && !advanceN;
    mask          = '0;
    if (selNext && !procTakes) begin
      if (!globalWrN)      mask = '1;
      else if (!byteWrEnN) mask = ~laneEnN;
    end
    strobes.wrMask = mask;
    strobes.drive  = readActive && !outEnN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selected   <= 1'b0;
      readActive <= 1'b0;
    end else begin
      selected   <= selNext;
      readActive <= selNext && (mask == '0);
    end
  end
endmodule

// File: rtl/burst_sram_dp.sv
module burst_sram_dp
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int LANE_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       interleave,
  input  logic [ADDR_W-1:0]          addrIn,
  input  logic [LANE_W*LANE_CNT-1:0] dataIn,
  input  sramStrobes_t               strobes,
  output logic [LANE_W*LANE_CNT-1:0] dataOut
);
  localparam int DATA_W = LANE_W * LANE_CNT;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HIGH_W = ADDR_W - BURST_W;

  logic [HIGH_W-1:0]  baseHigh;
  logic [BURST_W-1:0] startLow;
  logic [BURST_W-1:0] count;
  logic [BURST_W-1:0] countNext;
  logic [ADDR_W-1:0]  curAddr;
  logic [ADDR_W-1:0]  nextAddr;
  logic [DATA_W-1:0]  mergedWord;
  logic [DATA_W-1:0]  mem [DEPTH];

  function automatic logic [BURST_W-1:0] orderLow(input logic [BURST_W-1:0] start,
                                                  input logic [BURST_W-1:0] cnt,
                                                  input logic il);
    return il ? (start ^ cnt) : (start + cnt);
  endfunction

  always_comb begin
    countNext = count + 1'b1;
    curAddr   = {baseHigh, orderLow(startLow, count, interleave)};
    if (strobes.load)      nextAddr = addrIn;
    else if (strobes.step) nextAddr = {baseHigh, orderLow(startLow, countNext, interleave)};
    else                   nextAddr = curAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseHigh <= '0;
      startLow <= '0;
      count    <= '0;
    end else if (strobes.load) begin
      baseHigh <= addrIn[ADDR_W-1:BURST_W];
      startLow <= addrIn[BURST_W-1:0];
      count    <= '0;
    end else if (strobes.step) begin
      count    <= countNext;
    end
  end

  for (genvar g = 0; g < LANE_CNT; g++) begin : gLane
    assign mergedWord[g*LANE_W +: LANE_W] = strobes.wrMask[g] ? dataIn[g*LANE_W +: LANE_W]
                                                              : mem[nextAddr][g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (|strobes.wrMask) mem[nextAddr] <= mergedWord;
  end

  assign dataOut = strobes.drive ? mem[curAddr] : '0;
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       chipSel,
  input  logic                       procStrobeN,
  input  logic                       ctrlStrobeN,
  input  logic                       advanceN,
  input  logic                       interleave,
  input  logic [ADDR_W-1:0]          addrIn,
  input  logic                       byteWrEnN,
  input  logic [LANE_CNT-1:0]        laneEnN,
  input  logic                       globalWrN,
  input  logic                       outEnN,
  input  logic [LANE_W*LANE_CNT-1:0] dataIn,
  output logic [LANE_W*LANE_CNT-1:0] dataOut,
  output logic                       dataDrive
);
  sramStrobes_t strobes;

  burst_sram_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .chipSel    (chipSel),
    .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN),
    .advanceN   (advanceN),
    .byteWrEnN  (byteWrEnN),
    .laneEnN    (laneEnN),
    .globalWrN  (globalWrN),
    .outEnN     (outEnN),
    .strobes    (strobes)
  );

  burst_sram_dp #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .BURST_W(2)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .interleave(interleave),
    .addrIn    (addrIn),
    .dataIn    (dataIn),
    .strobes   (strobes),
    .dataOut   (dataOut)
  );

  assign dataDrive = strobes.drive;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              chipSel,
  input logic              procStrobeN,
  input logic              ctrlStrobeN,
  input logic              advanceN,
  input logic              interleave,
  input logic              byteWrEnN,
  input logic              globalWrN,
  input logic              outEnN,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataDrive
);
  // R12: output enable high blocks the pad at once
  assert_oe_blocks_R12: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dataDrive);

  // R12: idle pad reads zero
  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rstN)
    !dataDrive |-> dataOut == '0);

  // R2: controller strobe with chip deselected leaves nothing to drive
  assert_deselect_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(!ctrlStrobeN && !chipSel) |-> !dataDrive);

  // R11: a global write through the controller strobe is not a read
  assert_write_nodrive_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(!ctrlStrobeN && !globalWrN) |-> !dataDrive);

  // R6: a held burst keeps the same word on the pad
  assert_suspend_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(procStrobeN && ctrlStrobeN && advanceN && globalWrN && byteWrEnN)
     && $past(dataDrive) && dataDrive && $stable(interleave)) |-> $stable(dataOut));

  // R3: deselected processor strobe does not move the burst
  assert_proc_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!procStrobeN && !chipSel && ctrlStrobeN && advanceN && globalWrN && byteWrEnN)
     && $past(dataDrive) && dataDrive && $stable(interleave)) |-> $stable(dataOut));
endmodule

bind burst_sram burst_sram_chk #(.DATA_W(LANE_W*burst_sram_pkg::LANE_CNT)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .chipSel    (chipSel),
  .procStrobeN(procStrobeN),
  .ctrlStrobeN(ctrlStrobeN),
  .advanceN   (advanceN),
  .interleave (interleave),
  .byteWrEnN  (byteWrEnN),
  .globalWrN  (globalWrN),
  .outEnN     (outEnN),
  .dataOut    (dataOut),
  .dataDrive  (dataDrive)
);

// File: tb/test_burst_sram.sv
module test_burst_sram;
  localparam int CLK_NS = 4;
  localparam int AW     = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chipSel = 1'b0, procStrobeN = 1'b1, ctrlStrobeN = 1'b1, advanceN = 1'b1;
  logic        interleave = 1'b0, byteWrEnN = 1'b1, globalWrN = 1'b1, outEnN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [3:0]  laneEnN = 4'hF;
  logic [31:0] dataIn = '0;
  logic [31:0] dataOut;
  logic        dataDrive;

  int checks = 0, failures = 0;
  logic [31:0] refMem [1024];
  int  mBase = 0, mCnt = 0;
  bit  mSel = 0, mRead = 0;

  always #(CLK_NS/2) clk = ~clk;

  burst_sram #(.ADDR_W(AW), .LANE_W(8)) i_burst_sram (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN), .interleave(interleave),
    .addrIn(addrIn), .byteWrEnN(byteWrEnN), .laneEnN(laneEnN), .globalWrN(globalWrN),
    .outEnN(outEnN), .dataIn(dataIn), .dataOut(dataOut), .dataDrive(dataDrive)
  );

  function automatic int refAddr(int base, int cnt, bit il);
    int s = base % 4;
    int low = il ? (s ^ cnt) : ((s + cnt) % 4);
    return (base - s) + low;
  endfunction

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // one clock: drive, compare against the model, then advance the model
  task automatic cyc(input bit cN, input bit pN, input bit aN, input bit cs,
                     input int a, input bit gN, input bit bN, input logic [3:0] ln,
                     input logic [31:0] d, input bit oN, input bit il, input string tag);
    bit expDrive;
    logic [31:0] expOut;
    bit procTakes, load, selNext;
    logic [3:0] mask;
    int wa;
    @(negedge clk);
    ctrlStrobeN = cN; procStrobeN = pN; advanceN = aN; chipSel = cs;
    addrIn = a[AW-1:0]; globalWrN = gN; byteWrEnN = bN; laneEnN = ln;
    dataIn = d; outEnN = oN; interleave = il;
    #1;
    expDrive = mRead && !oN;
    expOut   = expDrive ? refMem[refAddr(mBase, mCnt, il)] : 32'h0;
    checks++;
    if (dataDrive !== expDrive || dataOut !== expOut) begin
      failures++;
      $display("FAIL %s drive/data actual=%0b/%h expected=%0b/%h",
               tag, dataDrive, dataOut, expDrive, expOut);
    end
    @(posedge clk);
    procTakes = !pN && cs;
    load      = procTakes || !cN;
    selNext   = load ? cs : mSel;
    if (load) begin
      mBase = a; mCnt = 0;
    end else if (mSel && !aN) begin
      mCnt = (mCnt + 1) % 4;
    end
    mask = 4'h0;
    if (selNext && !procTakes) begin
      if (!gN)      mask = 4'hF;
      else if (!bN) mask = ~ln;
    end
    wa = refAddr(mBase, mCnt, il);
    for (int i = 0; i < 4; i++)
      if (mask[i]) refMem[wa][8*i +: 8] = d[8*i +: 8];
    mSel  = selNext;
    mRead = selNext && (mask == 4'h0);
  endtask

  // shorthands
  task automatic ldRead(input int a, input bit il, input string tag);
    cyc(0, 1, 1, 1, a, 1, 1, 4'hF, 32'h0, 0, il, tag);
  endtask
  task automatic adv(input bit il, input string tag);
    cyc(1, 1, 0, 1, 0, 1, 1, 4'hF, 32'h0, 0, il, tag);
  endtask
  task automatic hold(input bit il, input string tag);
    cyc(1, 1, 1, 1, 0, 1, 1, 4'hF, 32'h0, 0, il, tag);
  endtask

  initial begin
    #(CLK_NS * 150000);
    checks++; failures++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1: idle after reset
    hold(0, "R1"); hold(0, "R1");
    // R11: fill every word with global-write bursts; write cycles never drive
    for (int b = 0; b < 256; b++) begin
      cyc(0, 1, 1, 1, b*4, 0, 1, 4'hF, (b*4)*32'h9E3779B1 + 32'd7, 0, 0, "R11");
      for (int k = 1; k < 4; k++)
        cyc(1, 1, 0, 1, 0, 0, 1, 4'hF, (b*4+k)*32'h9E3779B1 + 32'd7, 0, 0, "R11");
    end
    // R4: linear order from 2 wraps 2,3,0,1,2
    ldRead(10'h102, 0, "R4");
    for (int k = 0; k < 5; k++) adv(0, "R4");
    ldRead(10'h3FF, 0, "R4");
    for (int k = 0; k < 3; k++) adv(0, "R4");
    // R5: interleaved order
    ldRead(10'h205, 1, "R5");
    for (int k = 0; k < 3; k++) adv(1, "R5");
    ldRead(10'h3B3, 1, "R5");
    for (int k = 0; k < 4; k++) adv(1, "R5");
    // R6: suspend cycles inside a burst
    ldRead(10'h040, 0, "R6");
    adv(0, "R6"); hold(0, "R6"); hold(0, "R6"); adv(0, "R6"); hold(0, "R6"); adv(0, "R6");
    hold(1, "R6"); adv(1, "R6");
    // R7: controller strobe restarts a burst
    ldRead(10'h081, 0, "R7");
    adv(0, "R7");
    ldRead(10'h0C6, 0, "R7");
    adv(0, "R7"); adv(0, "R7"); adv(0, "R7");
    // R3: processor strobe loads when selected, ignored when not
    cyc(1, 0, 1, 1, 10'h111, 1, 1, 4'hF, 0, 0, 0, "R3");
    adv(0, "R3");
    cyc(1, 0, 1, 0, 10'h222, 1, 1, 4'hF, 0, 0, 0, "R3");
    hold(0, "R3"); adv(0, "R3"); adv(0, "R3");
    // R10: write enables on a processor strobe edge are dropped
    cyc(1, 0, 1, 1, 10'h130, 0, 0, 4'h0, 32'hDEADBEEF, 0, 0, "R10");
    hold(0, "R10"); adv(0, "R10");
    ldRead(10'h130, 0, "R10"); hold(0, "R10");
    // R8: byte-lane writes, partial and empty masks
    cyc(0, 1, 1, 1, 10'h140, 1, 0, 4'b1010, 32'h11223344, 0, 0, "R8");
    ldRead(10'h140, 0, "R8");
    cyc(1, 1, 1, 1, 0, 1, 0, 4'b1111, 32'h55667788, 0, 0, "R8");
    hold(0, "R8");
    cyc(1, 1, 0, 1, 0, 1, 0, 4'b0011, 32'h99AABBCC, 0, 0, "R8");
    ldRead(10'h140, 0, "R8"); adv(0, "R8"); adv(0, "R8");
    // R9: global write overrides lane enables
    cyc(0, 1, 1, 1, 10'h150, 0, 1, 4'hF, 32'hCAFEF00D, 0, 0, "R9");
    cyc(1, 1, 0, 1, 0, 0, 0, 4'b0111, 32'h0BADC0DE, 0, 0, "R9");
    ldRead(10'h150, 0, "R9"); adv(0, "R9"); adv(0, "R9");
    // R2: deselect, then writes and advances have no effect
    cyc(0, 1, 1, 0, 10'h160, 1, 1, 4'hF, 0, 0, 0, "R2");
    cyc(1, 1, 0, 1, 0, 0, 1, 4'hF, 32'hFFFF0000, 0, 0, "R2");
    cyc(1, 1, 1, 1, 0, 1, 0, 4'h0, 32'h0000FFFF, 0, 0, "R2");
    ldRead(10'h160, 0, "R2"); adv(0, "R2"); adv(0, "R2");
    // R12: output enable gates the pad without a clock edge
    cyc(0, 1, 1, 1, 10'h170, 1, 1, 4'hF, 0, 1, 0, "R12");
    cyc(1, 1, 1, 1, 0, 1, 1, 4'hF, 0, 1, 0, "R12");
    cyc(1, 1, 0, 1, 0, 1, 1, 4'hF, 0, 0, 0, "R12");
    cyc(1, 1, 1, 1, 0, 1, 1, 4'hF, 0, 1, 0, "R12");
    hold(0, "R12");
    report();
    $finish;
  end
endmodule